// File: doc/BRIEF.md
# Compare-Point Watchdog Timer

This block is a memory-mapped timer with one free-running counter and a bank of compare channels. The counter advances once every `TICK_DIV` clock cycles (one microsecond per tick when the clock is divided down to 1 MHz). Each channel holds an absolute compare value. When the counter steps onto that value, the channel sets a sticky status flag, and enabled flags drive a shared interrupt line.

One channel, `WDOG_CH`, doubles as the watchdog. There is no kick register. To service the watchdog, software first writes the snapshot register, which freezes a copy of the counter. It then reads that copy back and writes the copy plus the timeout into the watchdog channel's compare register. Moving the compare point ahead this way cancels the pending expiry. If the counter catches up while the watchdog is armed and the watchdog channel's interrupt enable is also set, a fixed-length reset pulse is issued. When the pulse ends, the arm bit clears itself. Software finds the time left as compare minus counter in modulo-2^32 arithmetic.

Top module: `cmp_wdog_timer`

## Requirements
- R1: The counter resets to 0, increments by exactly one every `TICK_DIV` clock cycles, wraps modulo 2^32, and reads at offset 0x00.
- R2: Channel i has a 32-bit compare register at offset 0x08 + 4*i (channel 5 at 0x1C). It is readable and writable and resets to 0.
- R3: A channel's status bit (bit i of the status register at offset 0x20) is set on the clock edge where the counter advances to equal that channel's compare value. It stays set until software writes 1 to that bit at 0x20. Written 0 bits have no effect, and a new match in the same cycle wins over the clear.
- R4: `irq_o` is registered and equals the OR over channels of status AND interrupt enable. The enable is a bit mask at offset 0x24, bits 5:0, one bit per channel. `irq_o` follows one clock after either input changes.
- R5: Writing a value with bit 0 = 1 to offset 0x30 copies the current counter into the snapshot register at 0x34. The snapshot holds until the next such write. A write to 0x30 with bit 0 = 0 leaves the snapshot unchanged, and 0x30 reads as 0.
- R6: When the watchdog channel (index 5) matches while the arm bit (offset 0x28, bit 0) and enable bit 5 are both 1, `wdog_rst_o` goes high for exactly `RST_PULSE` (16) clock cycles. It rises on the same edge the status bit sets.
- R7: With enable bit 5 at 0, or the arm bit at 0, a watchdog-channel match produces no reset pulse. The status bit is still set.
- R8: The arm bit reads back as 0 once a reset pulse has ended.
- R9: Rewriting the watchdog compare register to a value ahead of the counter, before the counter reaches the old value, prevents any reset pulse.
- R10: All registers reset to 0. Reads of unmapped offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data appears on `bus_rdata` after the next edge |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt, enabled status OR |
| wdog_rst_o | output | 1 | Watchdog reset pulse |

## Verification
The assertions assume that reset is held from time zero. They also assume that reads and writes are single-cycle strobes at word-aligned offsets, and that software never sets the arm bit in the same cycle a pulse ends. The stimulus drives every access as a one-cycle strobe on the falling edge. It sets compare points relative to a fresh snapshot, so each expiry lands a known number of ticks ahead. Channels that must stay quiet get compare values far beyond any counter value the run reaches.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFF_COUNT = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_CMP0  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_IEN   = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_ARM   = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_SNAPW = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_SNAPR = 8'h34;
endpackage

// File: rtl/wdt_tick.sv
module wdt_tick #(
  parameter int TICK_DIV = 200,
  parameter int CNT_W    = 32
) (
  input  logic             clk,
  input  logic             rst,
  output logic             tick_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_next_o
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0] div_q;

  assign tick_o     = (div_q == DIV_LAST);
  assign cnt_next_o = cnt_o + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      cnt_o <= '0;
    end else begin
      div_q <= tick_o ? '0 : div_q + 1'b1;
      if (tick_o) cnt_o <= cnt_next_o;
    end
  end

  // R1: the counter only ever moves forward by one
  a_r1_step_by_one: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt_o) |-> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/wdt_cmp_bank.sv
module wdt_cmp_bank #(
  parameter int N_CH  = 6,
  parameter int CNT_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       tick_i,
  input  logic [CNT_W-1:0]           cnt_next_i,
  input  logic [N_CH-1:0]            cmp_we_i,
  input  logic [CNT_W-1:0]           wdata_i,
  input  logic [N_CH-1:0]            clr_i,
  output logic [N_CH-1:0][CNT_W-1:0] cmp_o,
  output logic [N_CH-1:0]            status_o,
  output logic [N_CH-1:0]            hit_o
);
  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assign hit_o[i] = tick_i && (cnt_next_i == cmp_o[i]);

    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_o[i]    <= '0;
        status_o[i] <= 1'b0;
      end else begin
        if (cmp_we_i[i]) cmp_o[i] <= wdata_i;
        if (hit_o[i])      status_o[i] <= 1'b1;
        else if (clr_i[i]) status_o[i] <= 1'b0;
      end
    end
  end

  // R3: a set status bit only drops after a clear request
  a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
    (($past(status_o) & ~$past(clr_i) & ~status_o) == '0));
  // R3: a status bit only rises after a compare hit
  a_r3_rise_on_hit: assert property (@(posedge clk) disable iff (rst)
    ((status_o & ~$past(status_o) & ~$past(hit_o)) == '0));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int RST_PULSE = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  output logic pulse_o,
  output logic done_o
);
  localparam int PW = (RST_PULSE > 1) ? $clog2(RST_PULSE) : 1;

  logic [PW-1:0] left_q;

  assign done_o = pulse_o && (left_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_o <= 1'b0;
      left_q  <= '0;
    end else if (!pulse_o) begin
      if (fire_i) begin
        pulse_o <= 1'b1;
        left_q  <= PW'(RST_PULSE - 1);
      end
    end else if (left_q == '0) begin
      pulse_o <= 1'b0;
    end else begin
      left_q <= left_q - 1'b1;
    end
  end

  // R6: the pulse cannot end while cycles remain
  a_r6_pulse_holds: assert property (@(posedge clk) disable iff (rst)
    (pulse_o && left_q != '0) |=> pulse_o);
endmodule

// File: rtl/cmp_wdog_timer.sv
module cmp_wdog_timer
  import wdt_pkg::*;
#(
  parameter int TICK_DIV  = 200,
  parameter int N_CH      = 6,
  parameter int WDOG_CH   = 5,
  parameter int RST_PULSE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              wdog_rst_o
);
  logic                        tick;
  logic [DATA_W-1:0]           cnt, cnt_next, snap_q;
  logic [N_CH-1:0][DATA_W-1:0] cmp;
  logic [N_CH-1:0]             status, hit, cmp_we, clr, ien_q;
  logic                        arm_q, fire, done;
  logic [DATA_W-1:0]           rd_mux;

  wdt_tick #(.TICK_DIV(TICK_DIV), .CNT_W(DATA_W)) u_tick (
    .clk(clk), .rst(rst), .tick_o(tick), .cnt_o(cnt), .cnt_next_o(cnt_next));

  for (genvar i = 0; i < N_CH; i++) begin : g_we
    assign cmp_we[i] = bus_wr && (bus_addr == OFF_CMP0 + ADDR_W'(4 * i));
  end
  assign clr = (bus_wr && bus_addr == OFF_STAT) ? bus_wdata[N_CH-1:0] : '0;

  wdt_cmp_bank #(.N_CH(N_CH), .CNT_W(DATA_W)) u_bank (
    .clk(clk), .rst(rst), .tick_i(tick), .cnt_next_i(cnt_next),
    .cmp_we_i(cmp_we), .wdata_i(bus_wdata), .clr_i(clr),
    .cmp_o(cmp), .status_o(status), .hit_o(hit));

  assign fire = hit[WDOG_CH] && arm_q && ien_q[WDOG_CH];

  wdt_pulse #(.RST_PULSE(RST_PULSE)) u_pulse (
    .clk(clk), .rst(rst), .fire_i(fire), .pulse_o(wdog_rst_o), .done_o(done));

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q  <= '0;
      arm_q  <= 1'b0;
      snap_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == OFF_IEN) ien_q <= bus_wdata[N_CH-1:0];
      if (done) arm_q <= 1'b0;
      else if (bus_wr && bus_addr == OFF_ARM) arm_q <= bus_wdata[0];
      if (bus_wr && bus_addr == OFF_SNAPW && bus_wdata[0]) snap_q <= cnt;
      irq_o <= |(status & ien_q);
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      OFF_COUNT: rd_mux = cnt;
      OFF_STAT:  rd_mux = DATA_W'(status);
      OFF_IEN:   rd_mux = DATA_W'(ien_q);
      OFF_ARM:   rd_mux = DATA_W'(arm_q);
      OFF_SNAPR: rd_mux = snap_q;
      default:   rd_mux = '0;
    endcase
    for (int i = 0; i < N_CH; i++)
      if (bus_addr == OFF_CMP0 + ADDR_W'(4 * i)) rd_mux = cmp[i];
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R7: a pulse starts only if armed and enabled on the prior cycle
  a_r7_gated_start: assert property (@(posedge clk) disable iff (rst)
    $rose(wdog_rst_o) |-> ($past(arm_q) && $past(ien_q[WDOG_CH])));
  // R8: disarmed once the pulse ends
  a_r8_self_disarm: assert property (@(posedge clk) disable iff (rst)
    $fell(wdog_rst_o) |-> !arm_q);
  // R4: interrupt follows enabled status one cycle later
  a_r4_irq_follow: assert property (@(posedge clk) disable iff (rst)
    irq_o == |($past(status) & $past(ien_q)));
endmodule

// File: tb/cmp_wdog_timer_tb.sv
module cmp_wdog_timer_tb;
  localparam int TD = 4;
  localparam int NV = 12;
  // {addr, write data, expected read-back}
  localparam logic [71:0] VEC [NV] = '{
    {8'h08, 32'h1000_0000, 32'h1000_0000},
    {8'h0C, 32'h2000_0011, 32'h2000_0011},
    {8'h10, 32'hA5A5_0000, 32'hA5A5_0000},
    {8'h14, 32'h0F0F_F0F0, 32'h0F0F_F0F0},
    {8'h18, 32'h7777_0000, 32'h7777_0000},
    {8'h1C, 32'h8000_0005, 32'h8000_0005},
    {8'h24, 32'hFFFF_FFFF, 32'h0000_003F},
    {8'h28, 32'hFFFF_FFFF, 32'h0000_0001},
    {8'h04, 32'hDEAD_BEEF, 32'h0000_0000},
    {8'h3C, 32'h1234_5678, 32'h0000_0000},
    {8'h2C, 32'h5555_AAAA, 32'h0000_0000},
    {8'h30, 32'h0000_0000, 32'h0000_0000}
  };

  logic clk = 0, rst = 1, bus_wr = 0, bus_rd = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq_o, wdog_rst_o;
  int checks = 0, errors = 0, rst_hi = 0, cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cmp_wdog_timer #(.TICK_DIV(TD)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .wdog_rst_o(wdog_rst_o));

  always @(negedge clk) if (wdog_rst_o) rst_hi++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired: act=hung exp=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic snapshot(output logic [31:0] s);
    wr(8'h30, 32'h1);
    rd(8'h34, s);
  endtask

  initial begin
    logic [31:0] v, s, c, s2;
    int base;
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 / R1 reset state
    rd(8'h00, v); chk("R1 counter near zero after reset", {31'd0, v <= 2}, 32'd1);
    rd(8'h08, v); chk("R10 cmp0 reset", v, 0);
    rd(8'h1C, v); chk("R10 cmp5 reset", v, 0);
    rd(8'h20, v); chk("R10 status reset", v, 0);
    rd(8'h24, v); chk("R10 ien reset", v, 0);
    rd(8'h28, v); chk("R10 arm reset", v, 0);
    rd(8'h34, v); chk("R10 snapshot reset", v, 0);
    chk("R10 irq reset", {31'd0, irq_o}, 0);
    chk("R10 wdog_rst reset", {31'd0, wdog_rst_o}, 0);

    // R2 / R10 register vectors
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], v);
      chk($sformatf("R2 R10 vector %0d", i), v, VEC[i][31:0]);
    end
    rd(8'h08, v); chk("R10 cmp0 untouched by unmapped writes", v, 32'h1000_0000);
    wr(8'h28, 0); wr(8'h24, 0);

    // R1 tick rate: reads 40 edges apart differ by 10
    rd(8'h00, c); idle(39); rd(8'h00, v);
    chk("R1 ten ticks per forty cycles", v - c, 10);

    // R5 snapshot
    wr(8'h30, 1); rd(8'h00, c); rd(8'h34, s);
    chk("R5 snapshot equals counter", {31'd0, (c - s) <= 1}, 1);
    idle(40); rd(8'h34, v); chk("R5 snapshot holds", v, s);
    wr(8'h30, 32'hFFFF_FFFE); rd(8'h34, v); chk("R5 bit0 clear ignored", v, s);
    wr(8'h30, 1); rd(8'h34, v); chk("R5 new snapshot advances", {31'd0, v - s >= 10}, 1);

    // R3 / R4 compare and interrupt on channel 0
    snapshot(s); wr(8'h08, s + 8);
    rd(8'h20, v); chk("R3 no early status", v, 0);
    idle(50);
    rd(8'h20, v); chk("R3 status set on match", v, 1);
    chk("R4 irq masked", {31'd0, irq_o}, 0);
    wr(8'h24, 32'h1); idle(1);
    chk("R4 irq on enable", {31'd0, irq_o}, 1);
    wr(8'h20, 32'h3E); rd(8'h20, v); chk("R3 zero bit keeps status", v, 1);
    wr(8'h20, 32'h1); idle(1);
    chk("R4 irq drops after clear", {31'd0, irq_o}, 0);
    rd(8'h20, v); chk("R3 cleared by write one", v, 0);
    wr(8'h24, 0);

    // R6 / R8 watchdog expiry
    base = rst_hi;
    wr(8'h24, 32'h20); wr(8'h28, 1);
    snapshot(s); wr(8'h1C, s + 8);
    for (int k = 0; k < 100 && !wdog_rst_o; k++) @(negedge clk);
    rd(8'h20, v); chk("R6 status set with pulse", v, 32'h20);
    idle(30);
    chk("R6 pulse length", rst_hi - base, 16);
    chk("R6 irq asserted", {31'd0, irq_o}, 1);
    rd(8'h28, v); chk("R8 arm cleared", v, 0);
    wr(8'h20, 32'h20);

    // R7 gating
    base = rst_hi;
    wr(8'h24, 0); wr(8'h28, 1);
    snapshot(s); wr(8'h1C, s + 8); idle(60);
    chk("R7 no pulse with enable bit clear", rst_hi - base, 0);
    rd(8'h20, v); chk("R7 status still set", v, 32'h20);
    rd(8'h28, v); chk("R7 arm still set", v, 1);
    wr(8'h28, 0); wr(8'h24, 32'h20); wr(8'h20, 32'h20);
    snapshot(s); wr(8'h1C, s + 8); idle(60);
    chk("R7 no pulse when disarmed", rst_hi - base, 0);

    // R9 re-arm cancels expiry
    wr(8'h20, 32'h20); wr(8'h28, 1);
    base = rst_hi;
    snapshot(s); wr(8'h1C, s + 20); idle(20);
    snapshot(s2); wr(8'h1C, s2 + 4000); idle(120);
    chk("R9 no pulse after re-arm", rst_hi - base, 0);
    rd(8'h20, v); chk("R9 no status after re-arm", v, 0);
    rd(8'h28, v); chk("R9 arm kept", v, 1);
    wr(8'h28, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule